// File: doc/BRIEF.md
# Interleaved Multi-Bank Word Memory

This block is a word-addressable main store built from many narrow storage chips. Each chip holds one byte per entry. A row of chips placed side by side forms one bank, and each chip in the row carries one byte lane of the data word. Several such banks together cover the whole address range.

Every incoming word address is cut into two fields: a bank number and an entry index that goes to every chip of the chosen bank. A mode input picks where the bank number comes from. In interleaved mode it is taken from the lowest address bits, so consecutive words land in different banks. In banked mode it is taken from the highest address bits, so each bank owns one contiguous slice of the address range. Only the chosen bank is enabled for an access. A write stores the word in the same cycle. A read returns the word one clock later together with a one-cycle valid pulse.

Full size is 8 banks of four 1M-by-8 chips, which gives 8M 32-bit words on a 23-bit address. That is reached with `CHIP_AW = 20`. The defaults use a shallow chip so that the arrays stay small.

Top module: `mbm_interleaved_mem`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `rd_valid` is 0 and `rd_data` is 0 until the first read request.
- R2: A read (`req`=1, `wr`=0) sampled at edge t raises `rd_valid` for exactly the cycle after edge t, with the addressed word on `rd_data`. A write (`req`=1, `wr`=1) never raises `rd_valid`.
- R3: With `map_hi`=0 the bank number is `addr % BANKS` (the low bits) and the chip index is `addr / BANKS` (the remaining upper bits).
- R4: With `map_hi`=1 the bank number is `addr / DEPTH` (the top bits) and the chip index is `addr % DEPTH` (the low bits).
- R5: Changing `map_hi` moves no stored data. A word written under one mode is read back under the other mode at whatever address maps to the same bank and index.
- R6: An access enables at most one bank. A write changes only the single word at the mapped bank and index, and every other stored word keeps its value.
- R7: When `req` is 0, `wr`, `addr`, `wr_data` and `map_hi` have no effect: storage is unchanged and `rd_valid` is 0 in the next cycle.
- R8: `rd_data` is 0 in every cycle where `rd_valid` is 0.
- R9: A read issued in the cycle right after a write to the same location returns the newly written word. Chip lane k stores bits 8k+7..8k of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Access request for this cycle |
| wr | input | 1 | 1 = write, 0 = read (only meaningful with `req`) |
| map_hi | input | 1 | 0 = bank from low address bits, 1 = bank from high address bits |
| addr | input | AW (9 by default) | Word address |
| wr_data | input | DW (32) | Word to store |
| rd_data | output | DW (32) | Word read back; 0 when not valid |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` as valid |

## Verification
A write takes effect at the clock edge where it is sampled. A read answer appears after that edge, one register stage later, on `rd_valid` and `rd_data`. The bench drives each access on the falling edge. It then waits for the next rising edge plus a small delay, and compares both outputs against a behavioural word array addressed by bank and index, computed with integer division and remainder. The model takes a write into account only after it has checked the outputs of that same cycle. As a result, the read that follows in the next cycle must already see the new word, and no later edge is needed to sample any result.

// File: rtl/mbm_pkg.sv
// Package mbm_pkg
// Shared definitions for the multi-bank memory: the mapping mode type and
// the width of one chip lane. Assumes byte-wide chips.
package mbm_pkg;
    localparam int LANE_W = 8;

    typedef enum logic {
        MAP_LOW  = 1'b0,   // bank taken from least significant address bits
        MAP_HIGH = 1'b1    // bank taken from most significant address bits
    } map_mode_e;
endpackage

// File: rtl/mbm_addr_split.sv
// Module mbm_addr_split
// Splits a word address into bank number and in-chip index according to
// the mapping mode. Purely combinational. Assumes the bank count is a power
// of two, so AW = BW + IW.
module mbm_addr_split
    import mbm_pkg::*;
#(
    parameter int BW = 3,
    parameter int IW = 6,
    localparam int AW = BW + IW
) (
    input  map_mode_e        mode,
    input  logic [AW-1:0]    addr,
    output logic [BW-1:0]    bank,
    output logic [IW-1:0]    index
);
    // Pick the field boundaries from the mapping mode.
    always_comb begin
        if (mode == MAP_HIGH) begin
            bank  = addr[AW-1 -: BW];
            index = addr[IW-1:0];
        end else begin
            bank  = addr[BW-1:0];
            index = addr[AW-1 -: IW];
        end
    end
endmodule

// File: rtl/mbm_chip.sv
// Module mbm_chip
// Model of one byte-wide storage chip with 2**IW entries. A write stores
// on the enabled edge; a read registers the entry onto dout. When not
// enabled the chip keeps both its contents and its output.
module mbm_chip
    import mbm_pkg::*;
#(
    parameter int IW = 6,
    localparam int DEPTH = 1 << IW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [IW-1:0]     idx,
    input  logic [LANE_W-1:0] din,
    output logic [LANE_W-1:0] dout
);
    logic [LANE_W-1:0] cells [DEPTH];

    // Store on enabled writes; capture the entry on enabled reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (en) begin
            if (we) cells[idx] <= din;
            else    dout       <= cells[idx];
        end
    end

    // R6: a chip that is not enabled keeps its output register.
    a_r6_chip_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(dout));
endmodule

// File: rtl/mbm_bank.sv
// Module mbm_bank
// One bank: LANES byte-wide chips side by side sharing enable, write and
// index. Lane k carries word bits 8k+7..8k.
module mbm_bank
    import mbm_pkg::*;
#(
    parameter int IW    = 6,
    parameter int LANES = 4,
    localparam int DW   = LANES * LANE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    // One chip per byte lane.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        mbm_chip #(.IW(IW)) u_chip (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (en),
            .we   (we),
            .idx  (idx),
            .din  (din[k*LANE_W +: LANE_W]),
            .dout (dout[k*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/mbm_interleaved_mem.sv
// Module mbm_interleaved_mem
// Word memory of BANKS banks, each of LANES byte chips with 2**CHIP_AW
// entries. The address split is chosen at run time by map_hi. Reads return
// one cycle after the request with a one-cycle valid pulse. Assumes BANKS
// is a power of two and at least 2. Requests during reset are ignored.
module mbm_interleaved_mem
    import mbm_pkg::*;
#(
    parameter int BANKS   = 8,
    parameter int CHIP_AW = 6,
    parameter int LANES   = 4,
    localparam int BW = $clog2(BANKS),
    localparam int AW = BW + CHIP_AW,
    localparam int DW = LANES * LANE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          wr,
    input  logic          map_hi,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    logic [BW-1:0]      bank_sel;
    logic [CHIP_AW-1:0] chip_idx;
    logic [BANKS-1:0]   bank_en;
    logic [DW-1:0]      bank_out [BANKS];
    logic [BW-1:0]      rd_bank_q;
    logic               rd_valid_q;
    logic               active;
    map_mode_e          mode;

    assign active = req & rst_n;
    assign mode   = map_mode_e'(map_hi);

    mbm_addr_split #(.BW(BW), .IW(CHIP_AW)) u_split (
        .mode (mode),
        .addr (addr),
        .bank (bank_sel),
        .index(chip_idx)
    );

    // Decode one enable per bank and instantiate the bank.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign bank_en[b] = active && (bank_sel == BW'(b));

        mbm_bank #(.IW(CHIP_AW), .LANES(LANES)) u_bank (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (bank_en[b]),
            .we   (wr),
            .idx  (chip_idx),
            .din  (wr_data),
            .dout (bank_out[b])
        );
    end

    // Remember which bank answers a read and flag the answer for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_bank_q  <= '0;
        end else begin
            rd_valid_q <= active & ~wr;
            if (active & ~wr) rd_bank_q <= bank_sel;
        end
    end

    // Present the answering bank's word only while it is valid.
    always_comb begin
        rd_data  = rd_valid_q ? bank_out[rd_bank_q] : '0;
        rd_valid = rd_valid_q;
    end

    // R2: a read request produces a valid answer in the next cycle.
    a_r2_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wr) |=> rd_valid);

    // R2: a write request produces no valid pulse.
    a_r2_quiet_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req && wr) |=> !rd_valid);

    // R7: no request, no answer.
    a_r7_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rd_valid);

    // R6: never more than one bank enabled.
    a_r6_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_en));
endmodule

// File: tb/mbm_interleaved_mem_test.sv
module mbm_interleaved_mem_test;
    localparam int CLK_PERIOD = 10;
    localparam int BANKS = 8;
    localparam int DEPTH = 64;
    localparam int WORDS = BANKS * DEPTH;
    localparam int AW    = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          wr = 1'b0;
    logic          map_hi = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic          rd_valid;

    int total = 0;
    int bad = 0;
    logic [31:0] model [WORDS];

    mbm_interleaved_mem uut (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .map_hi(map_hi),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int phys(input logic hi, input int a);
        if (hi) return (a / DEPTH) * DEPTH + (a % DEPTH);
        else    return (a % BANKS) * DEPTH + (a / BANKS);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One access per cycle; outputs checked after the next rising edge.
    task automatic op(input logic r, input logic w, input logic hi,
                      input int a, input logic [31:0] d, input string tag);
        logic [31:0] exp_data;
        logic        exp_valid;
        int p;
        @(negedge clk);
        req = r; wr = w; map_hi = hi; addr = AW'(a); wr_data = d;
        p = phys(hi, a);
        exp_valid = r && !w;
        exp_data  = exp_valid ? model[p] : 32'h0;
        @(posedge clk);
        #1;
        check("R2 valid", {31'b0, rd_valid}, {31'b0, exp_valid});
        check(tag, rd_data, exp_data);
        if (r && w) model[p] = d;
    endtask

    function automatic logic [31:0] pat(input int a, input int seed);
        return (32'(a) * 32'h01030507) ^ (32'(seed) * 32'h9E3779B9);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL R2 watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid", {31'b0, rd_valid}, 32'h0);
        check("R1 data", rd_data, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 valid after release", {31'b0, rd_valid}, 32'h0);
        check("R8 data idle", rd_data, 32'h0);

        // R3: fill and read back under low-order mapping
        for (int a = 0; a < WORDS; a++) op(1, 1, 0, a, pat(a, 1), "R8 write no data");
        for (int a = 0; a < WORDS; a++) op(1, 0, 0, a, 32'h0, "R3 low read");

        // R4 and R5: same storage seen through the high-order split
        for (int a = 0; a < WORDS; a++) op(1, 0, 1, a, 32'h0, "R4 high read");
        for (int a = 0; a < WORDS; a += 7) op(1, 1, 1, a, pat(a, 2), "R8 write no data");
        for (int a = 0; a < WORDS; a++) op(1, 0, 0, a, 32'h0, "R5 low after high write");

        // R7: idle cycles with noisy inputs change nothing
        for (int i = 0; i < 40; i++) op(0, 1, i[0], i * 13, 32'hDEAD0000 | 32'(i), "R7 idle");
        for (int a = 0; a < WORDS; a++) op(1, 0, 1, a, 32'h0, "R6 R7 readback");

        // R9: write then immediate read, distinct byte lanes
        for (int a = 0; a < 32; a++) begin
            op(1, 1, a[1], a * 5, 32'h11223344 + 32'(a) * 32'h01010101, "R8 write no data");
            op(1, 0, a[1], a * 5, 32'h0, "R9 read after write");
        end

        // Mixed traffic: reads, writes, idles, both mappings
        for (int i = 0; i < 2000; i++) begin
            int unsigned rnd;
            rnd = $urandom;
            op(rnd[0] | rnd[1], rnd[2], rnd[3], int'(rnd[31:12] % WORDS),
               $urandom, "R6 mixed traffic");
        end
        for (int a = 0; a < WORDS; a++) op(1, 0, 0, a, 32'h0, "R6 final readback");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule